// File: doc/BRIEF.md
# Synchronous Loadable Binary Counter

This block is a binary up-counter whose every change happens on the rising clock edge. Each edge applies exactly one action, chosen in a fixed priority order:

1. A synchronous clear.
2. A parallel load of a data word.
3. A single increment.
4. Hold.

The clear and load controls are active low. Counting needs two enables to be high together.

A carry output goes high when the count is at its all-ones value and the chaining enable is high. It does not look at the other enable. It is combinational, so it can change in the middle of a clock cycle.

Wider counters are built by chaining. Each stage's carry output feeds the chaining enable of the next stage. All stages share the clock, the clear, the load and the other enable. A different modulus is made with logic outside the block. For example, driving the load from the inverted carry with a start value on the data inputs makes the counter repeat a shorter cycle.

Top module: `sbc_counter`

## Requirements
- R1: While clrN is 0, the count is 0 after the next rising edge, whatever loadN, enP, enT and dataIn are.
- R2: When clrN is 1 and loadN is 0, the count equals dataIn after the rising edge, whatever enP and enT are.
- R3: When clrN and loadN are 1 and both enP and enT are 1, the count rises by one at the rising edge.
- R4: When clrN and loadN are 1 and either enP or enT is 0, the count keeps its value across the edge.
- R5: Counting from the all-ones value (15 for WIDTH=4) gives 0, so a free-running counter divides by 2^WIDTH.
- R6: carryOut is 1 exactly when enT is 1 and the count is all ones. It does not depend on enP and follows enT with no clock delay.
- R7: Two 4-bit instances form an 8-bit counter when the first stage's carryOut drives the second stage's enT and the two share clk, clrN, loadN and enP. The second stage's carryOut is 1 at the combined count 255.
- R8: With enP and enT at 1, dataIn at 5 and loadN driven by the inverse of carryOut, the count repeats 5, 6, ..., 15, 5: a cycle of 11 states.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Synchronous clear, active low, highest priority |
| loadN | input | 1 | Synchronous parallel load, active low |
| enP | input | 1 | Count enable that gates counting only |
| enT | input | 1 | Count enable that also gates carryOut; chaining input |
| dataIn | input | WIDTH | Parallel load word |
| count | output | WIDTH | Current count |
| carryOut | output | 1 | Terminal-count carry, gated by enT |

## Verification
Every instance in the bench uses the default WIDTH of 4. With that width the all-ones state is at most sixteen increments away, so random clears, loads and enable patterns reach it often. This tests the wrap to zero, and the carry with enP both high and low, many times per run. Two more WIDTH=4 instances are chained to run through all 256 combined states. A final phase drives the load from the inverted carry to observe the 11-state cycle.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  // One strobe per edge action; at most one is high in any cycle.
  typedef struct packed {
    logic clearStb;
    logic loadStb;
    logic countStb;
  } ctrl_strobe_t;
endpackage

// File: rtl/sbc_ctrl.sv
module sbc_ctrl
  import sbc_pkg::*;
(
  input  logic         clk,
  input  logic         clrN,
  input  logic         loadN,
  input  logic         enP,
  input  logic         enT,
  output ctrl_strobe_t strobe
);
  logic clearReq;
  logic loadReq;
  logic countReq;

  // Decode the active-low controls, then apply clear > load > count.
  always_comb begin
    clearReq = ~clrN;
    loadReq  = ~loadN;
    countReq = enP & enT;
    strobe.clearStb = clearReq;
    strobe.loadStb  = loadReq & ~clearReq;
    strobe.countStb = countReq & ~loadReq & ~clearReq;
  end

  // A clear request must win whatever load does
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (1'b0)
    !clrN |-> !strobe.loadStb && !strobe.countStb); // R1

  // Either enable low blocks the increment
  AST_ENABLE_GATE: assert property (@(posedge clk) disable iff (!clrN)
    (!enP || !enT) |-> !strobe.countStb); // R4
endmodule

// File: rtl/sbc_datapath.sv
module sbc_datapath
  import sbc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  ctrl_strobe_t     strobe,
  input  logic             enT,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  localparam logic [WIDTH-1:0] TERMINAL = {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE      = {{(WIDTH-1){1'b0}}, 1'b1};

  logic [WIDTH-1:0] countReg;
  logic [WIDTH-1:0] countNext;
  logic             atTerminal;

  // Next-state selection follows the strobe priority.
  always_comb begin
    if (strobe.clearStb)      countNext = '0;
    else if (strobe.loadStb)  countNext = dataIn;
    else if (strobe.countStb) countNext = countReg + ONE;
    else                      countNext = countReg;
  end

  always_ff @(posedge clk) begin
    countReg <= countNext;
  end

  assign atTerminal = (countReg == TERMINAL);
  assign carryOut   = atTerminal & enT;
  assign count      = countReg;

  // The edge after a clear leaves the count at zero
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!clrN)
    $past(!clrN) |-> countReg == '0); // R1

  // A load captures the data word present at the edge
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!clrN)
    strobe.loadStb |=> countReg == $past(dataIn)); // R2

  // A count strobe adds exactly one, modulo 2^WIDTH
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!clrN)
    strobe.countStb |=> countReg == $past(countReg) + ONE); // R3

  // No strobe means the count keeps its value
  AST_HOLD: assert property (@(posedge clk) disable iff (!clrN)
    (!strobe.clearStb && !strobe.loadStb && !strobe.countStb) |=> $stable(countReg)); // R4
endmodule

// File: rtl/sbc_counter.sv
module sbc_counter
  import sbc_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enP,
  input  logic             enT,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);
  ctrl_strobe_t strobe;

  sbc_ctrl ctrl_i (
    .clk    (clk),
    .clrN   (clrN),
    .loadN  (loadN),
    .enP    (enP),
    .enT    (enT),
    .strobe (strobe)
  );

  sbc_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk      (clk),
    .clrN     (clrN),
    .strobe   (strobe),
    .enT      (enT),
    .dataIn   (dataIn),
    .count    (count),
    .carryOut (carryOut)
  );

  // Carry plus enP while idle means the next value is zero
  AST_CARRY_WRAP: assert property (@(posedge clk) disable iff (!clrN)
    (carryOut && enP && loadN) |=> count == '0); // R5

  // The carry is never high while the chaining enable is low
  AST_CARRY_GATED: assert property (@(posedge clk) disable iff (!clrN)
    !enT |-> !carryOut); // R6
endmodule

// File: tb/sbc_counter_tb_top.sv
module sbc_counter_tb_top;
  localparam int W = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  // Bench-side drives for the main instance.
  logic         clrN = 1'b0, loadN = 1'b1, enP = 1'b0, enT = 1'b0;
  logic [W-1:0] dataIn = '0;
  logic         div11Mode = 1'b0;
  logic         dutLoadN;
  logic [W-1:0] count;
  logic         carryOut;

  // In the divide-by-11 phase, outside logic drives the load from the carry.
  assign dutLoadN = div11Mode ? ~carryOut : loadN;

  sbc_counter #(.WIDTH(W)) dut_i (
    .clk(clk), .clrN(clrN), .loadN(dutLoadN), .enP(enP), .enT(enT),
    .dataIn(dataIn), .count(count), .carryOut(carryOut)
  );

  // Two chained stages form an 8-bit counter.
  logic         chClrN = 1'b0, chEn = 1'b0;
  logic [W-1:0] loCount, hiCount;
  logic         loCarry, hiCarry;

  sbc_counter #(.WIDTH(W)) lo_i (
    .clk(clk), .clrN(chClrN), .loadN(1'b1), .enP(chEn), .enT(chEn),
    .dataIn('0), .count(loCount), .carryOut(loCarry)
  );
  sbc_counter #(.WIDTH(W)) hi_i (
    .clk(clk), .clrN(chClrN), .loadN(1'b1), .enP(chEn), .enT(loCarry),
    .dataIn('0), .count(hiCount), .carryOut(hiCarry)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Reference next value, taken from the requirements.
  function automatic logic [W-1:0] nextCount(logic [W-1:0] cur, logic c, logic l,
                                             logic p, logic t, logic [W-1:0] d);
    if (!c)          return '0;
    else if (!l)     return d;
    else if (p && t) return cur + 1'b1;
    else             return cur;
  endfunction

  function automatic logic expCarry(logic [W-1:0] cur, logic t);
    return t && (cur == {W{1'b1}});
  endfunction

  logic [W-1:0] model;

  // Drive one cycle's inputs at the falling edge, check the carry, then step the model.
  task automatic stepDrive(input logic c, input logic l, input logic p, input logic t,
                           input logic [W-1:0] d, input string tag);
    clrN = c; loadN = l; enP = p; enT = t; dataIn = d;
    #1;
    check(tag, int'(carryOut), int'(expCarry(model, t)));
    model = nextCount(model, c, l, p, t, d);
    @(negedge clk);
    check(tag, int'(count), int'(model));
  endtask

  initial begin
    process::self().srandom(32'd1234);
    @(negedge clk);
    model = 'x;
    // Reset state: clear with load and enables active (R1 priority)
    stepDrive(1'b0, 1'b0, 1'b1, 1'b1, 4'd9, "R1");
    check("R1", int'(count), 0);
    // Load beats counting (R2)
    stepDrive(1'b1, 1'b0, 1'b1, 1'b1, 4'd12, "R2");
    // Count three times (R3)
    for (int i = 0; i < 3; i++) stepDrive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R3");
    check("R3", int'(count), 15);
    // At 15: enP low holds (R4) while carry stays high with enT (R6)
    stepDrive(1'b1, 1'b1, 1'b0, 1'b1, 4'd0, "R6");
    check("R4", int'(count), 15);
    clrN = 1'b1; loadN = 1'b1; enP = 1'b0; enT = 1'b1; #1;
    check("R6", int'(carryOut), 1);
    enT = 1'b0; #1;
    check("R6", int'(carryOut), 0);
    // enT low also holds (R4)
    stepDrive(1'b1, 1'b1, 1'b1, 1'b0, 4'd0, "R4");
    check("R4", int'(count), 15);
    // Wrap 15 to 0 (R5)
    stepDrive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R5");
    check("R5", int'(count), 0);
    // Free run of 16 returns to 0 (R5)
    for (int i = 0; i < 16; i++) stepDrive(1'b1, 1'b1, 1'b1, 1'b1, 4'd0, "R5");
    check("R5", int'(count), 0);

    // Constrained random mix (R1 to R6)
    for (int i = 0; i < 3000; i++) begin
      logic c, l, p, t;
      c = ($urandom_range(0, 15) != 0);
      l = ($urandom_range(0, 7) != 0);
      p = ($urandom_range(0, 3) != 0);
      t = ($urandom_range(0, 3) != 0);
      stepDrive(c, l, p, t, W'($urandom), "R3");
    end

    // Divide-by-11 via outside load logic (R8)
    stepDrive(1'b0, 1'b1, 1'b1, 1'b1, 4'd5, "R8");
    div11Mode = 1'b1;
    clrN = 1'b1; enP = 1'b1; enT = 1'b1; dataIn = 4'd5;
    for (int i = 1; i <= 40; i++) begin
      @(negedge clk);
      // From 0, after i edges: counts i up to 15, then cycles 5..15.
      if (i <= 15) check("R8", int'(count), i);
      else check("R8", int'(count), 5 + ((i - 16) % 11));
    end
    div11Mode = 1'b0;

    // Cascaded 8-bit counter (R7)
    @(negedge clk);
    chClrN = 1'b0; chEn = 1'b1;
    @(negedge clk);
    chClrN = 1'b1;
    check("R7", int'({hiCount, loCount}), 0);
    for (int i = 1; i <= 300; i++) begin
      @(negedge clk);
      check("R7", int'({hiCount, loCount}), i % 256);
      check("R7", int'(hiCarry), int'((i % 256) == 255));
    end
    // Holding the chain enable freezes both stages (R7)
    chEn = 1'b0;
    @(negedge clk);
    check("R7", int'({hiCount, loCount}), 300 % 256);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule